// File: doc/BRIEF.md
# CAN Bit Time Segment Sequencer

This block cuts each nominal CAN bit into time quanta and walks through three segments: a fixed one-quantum synchronization segment, a first phase segment that covers propagation delay plus phase buffer 1, and a second phase segment. A prescaler makes the time quantum from the module clock. Two single-clock strobes come out of the block. The transmit point marks the first clock of every bit. The sample point marks the first clock of the second phase segment.

The whole timing setup comes from one packed configuration word, and every field in it holds its value minus one. The controller that owns the bus state supplies three inputs: whether the bus is idle, whether hard synchronization is allowed, and whether the node is driving a dominant bit. On a recessive-to-dominant transition of the receive line, the block either restarts the bit (hard synchronization while idle) or moves the sample point by a bounded amount (resynchronization while busy).

Top module: `can_bit_timer`

## Requirements
- R1: The time quantum P equals the prescaler field plus one module clocks. The distance between successive tx_point_o pulses is (1 + T1 + T2) × P clocks when no edge occurs.
- R2: sample_o pulses (1 + T1) × P clocks after the tx_point_o pulse. T1 is the first-phase field plus one.
- R3: Configuration word layout. Bits [5:0] hold the prescaler, bits [7:6] the jump-width field (jump limit S = field + 1 quanta), bits [11:8] the first-phase field and bits [14:12] the second-phase field.
- R4: T2 is the second-phase field plus one, but never less than MIN_SEG2_TQ (default 2). A field value of 0 therefore gives 2 quanta.
- R5: During reset, tx_point_o is 1 and sample_o is 0. The cycle in which rst_ni is released is the first clock of a bit, so sample_o follows (1 + T1) × P clocks after that cycle.
- R6: A falling edge of rx_i is a cycle with rx_i = 0 whose previous clock had rx_i = 1. Such an edge, seen while bus_idle_i = 1 and hard_sync_en_i = 1, restarts the bit, and tx_point_o is high in the next cycle. With hard_sync_en_i = 0, edges seen while idle change nothing.
- R7: If a falling edge arrives while busy, in quantum k (counted from 0) of the first phase segment, that segment grows by min(k + 1, S) quanta.
- R8: If a falling edge arrives while busy, in quantum k of the second phase segment, that segment shrinks by min(T2 − 1 − k, S) quanta.
- R9: A falling edge during the synchronization segment causes no correction.
- R10: Only the first edge in a bit that arrives while busy and outside the sync segment takes part in resynchronization. Later edges in the same bit are ignored.
- R11: Edges that arrive while tx_dom_i = 1 are ignored.
- R12: btr_i is captured only in the first clock of a bit. A change made mid-bit affects the next bit only.
- R13: sample_o and tx_point_o are never high together, and sample_o is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btr_i | input | 15 | Packed timing configuration (fields minus one) |
| rx_i | input | 1 | Receive line, 0 = dominant |
| bus_idle_i | input | 1 | 1 while the bus is idle |
| hard_sync_en_i | input | 1 | Allows hard synchronization on idle edges |
| tx_dom_i | input | 1 | 1 while the node transmits a dominant bit |
| sample_o | output | 1 | One-clock strobe at the sample point |
| tx_point_o | output | 1 | One-clock strobe at the start of each bit |

## Verification
Each result is due at a fixed number of clocks after its stimulus:
- tx_point_o rises one cycle after the cycle that holds the hard-sync edge.
- sample_o comes (1 + T1 + extension) × P clocks after the tx_point_o cycle.
- The next tx_point_o comes (T2 − shortening) × P clocks after the sample_o cycle.

The bench keeps a cycle count that advances on each rising edge, and it drives and samples only on falling edges. Each edge is placed at the first clock of the chosen quantum by counting from the last observed strobe. Measured strobe distances are compared with the figures that follow from the requirements. This is done for a sweep over every first- and second-phase field value at three prescaler settings.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int unsigned BRP_W = 6;
  localparam int unsigned SJW_W = 2;
  localparam int unsigned TS1_W = 4;
  localparam int unsigned TS2_W = 3;
  localparam int unsigned BTR_W = TS2_W + TS1_W + SJW_W + BRP_W;
  // segment length incl. worst-case extension
  localparam int unsigned LEN_W = TS1_W + 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  typedef struct packed {
    logic [TS2_W-1:0] ts2;
    logic [TS1_W-1:0] ts1;
    logic [SJW_W-1:0] sjw;
    logic [BRP_W-1:0] brp;
  } btr_t;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o
);
  logic [BRP_W-1:0] cnt_q;

  assign tick_o = (cnt_q == brp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hard_sync_i,
  input  logic             resync_i,
  input  logic [LEN_W-1:0] t1_len_i,
  input  logic [LEN_W-1:0] t2_len_i,
  input  logic [LEN_W-1:0] sjw_len_i,
  output seg_e             seg_o,
  output logic             sample_o,
  output logic             tx_point_o
);
  seg_e             seg_q;
  logic [LEN_W-1:0] tq_q, len_q, len_eff, perr, corr;
  logic             rsd_q, rs_hit, seg_end;

  // phase error in quanta, clipped to jump width
  always_comb begin
    len_eff = len_q;
    perr    = '0;
    corr    = '0;
    rs_hit  = 1'b0;
    if (resync_i && !rsd_q && seg_q != SEG_SYNC) begin
      rs_hit  = 1'b1;
      perr    = (seg_q == SEG_PH1) ? tq_q + LEN_W'(1) : len_q - tq_q - LEN_W'(1);
      corr    = (perr < sjw_len_i) ? perr : sjw_len_i;
      len_eff = (seg_q == SEG_PH1) ? len_q + corr : len_q - corr;
    end
    seg_end = tick_i && (tq_q + LEN_W'(1) >= len_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q      <= SEG_SYNC;
      tq_q       <= '0;
      len_q      <= '0;
      rsd_q      <= 1'b0;
      sample_o   <= 1'b0;
      tx_point_o <= 1'b1;
    end else if (hard_sync_i) begin
      seg_q      <= SEG_SYNC;
      tq_q       <= '0;
      rsd_q      <= 1'b0;
      sample_o   <= 1'b0;
      tx_point_o <= 1'b1;
    end else begin
      sample_o   <= 1'b0;
      tx_point_o <= 1'b0;
      len_q      <= len_eff;
      if (rs_hit) rsd_q <= 1'b1;
      if (tick_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_PH1;
            tq_q  <= '0;
            len_q <= t1_len_i;
          end
          SEG_PH1: begin
            if (seg_end) begin
              seg_q    <= SEG_PH2;
              tq_q     <= '0;
              len_q    <= t2_len_i;
              sample_o <= 1'b1;
            end else begin
              tq_q <= tq_q + 1'b1;
            end
          end
          default: begin
            if (seg_end) begin
              seg_q      <= SEG_SYNC;
              tq_q       <= '0;
              rsd_q      <= 1'b0;
              tx_point_o <= 1'b1;
            end else begin
              tq_q <= tq_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int unsigned MIN_SEG2_TQ = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BTR_W-1:0] btr_i,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic             hard_sync_en_i,
  input  logic             tx_dom_i,
  output logic             sample_o,
  output logic             tx_point_o
);
  btr_t             cfg_q, cfg_eff;
  logic             tick, fall, hard_sync, resync;
  logic [LEN_W-1:0] t1_len, t2_raw, t2_len, sjw_len;
  seg_e             seg;

  // config is taken only in the first clock of a bit
  assign cfg_eff = tx_point_o ? btr_t'(btr_i) : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_eff;
  end

  assign t1_len  = LEN_W'(cfg_eff.ts1) + LEN_W'(1);
  assign t2_raw  = LEN_W'(cfg_eff.ts2) + LEN_W'(1);
  assign sjw_len = LEN_W'(cfg_eff.sjw) + LEN_W'(1);

  generate
    if (MIN_SEG2_TQ > 1) begin : g_seg2_floor
      assign t2_len = (t2_raw < LEN_W'(MIN_SEG2_TQ)) ? LEN_W'(MIN_SEG2_TQ) : t2_raw;
    end else begin : g_seg2_raw
      assign t2_len = t2_raw;
    end
  endgenerate

  assign hard_sync = fall & hard_sync_en_i & bus_idle_i;
  assign resync    = fall & ~bus_idle_i & ~tx_dom_i;

  can_bt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (fall)
  );

  can_bt_prescaler u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (hard_sync),
    .brp_i     (cfg_eff.brp),
    .tick_o    (tick)
  );

  can_bt_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .hard_sync_i (hard_sync),
    .resync_i    (resync),
    .t1_len_i    (t1_len),
    .t2_len_i    (t2_len),
    .sjw_len_i   (sjw_len),
    .seg_o       (seg),
    .sample_o    (sample_o),
    .tx_point_o  (tx_point_o)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk
  import can_bt_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic sample_o,
  input logic tx_point_o,
  input logic hs_i,
  input seg_e seg_i,
  input btr_t cfg_i
);
  // R13
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && tx_point_o));

  // R13
  sample_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  // R2
  sample_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> seg_i == SEG_PH2);

  // R1
  txpt_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_point_o |-> seg_i == SEG_SYNC);

  // R6
  hard_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_i |=> (tx_point_o && seg_i == SEG_SYNC));

  // R6
  no_early_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_i == SEG_PH1) |=> (seg_i != SEG_SYNC) || $past(hs_i));

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_point_o |=> $stable(cfg_i));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_o   (sample_o),
  .tx_point_o (tx_point_o),
  .hs_i       (hard_sync),
  .seg_i      (seg),
  .cfg_i      (cfg_q)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  import can_bt_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [BTR_W-1:0] btr;
  logic             rx = 1'b1, idle = 1'b1, hs_en = 1'b1, tx_dom = 1'b0;
  logic             sample_o, tx_point_o;
  int               cyc = 0, total = 0, fails = 0;
  int               ovl = 0, wide = 0;
  bit               smp_prev = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .btr_i          (btr),
    .rx_i           (rx),
    .bus_idle_i     (idle),
    .hard_sync_en_i (hs_en),
    .tx_dom_i       (tx_dom),
    .sample_o       (sample_o),
    .tx_point_o     (tx_point_o)
  );

  // R13 monitor
  always @(negedge clk) if (rst_n) begin
    if (sample_o && tx_point_o) ovl++;
    if (sample_o && smp_prev) wide++;
    smp_prev = sample_o;
  end

  function automatic logic [BTR_W-1:0] mk(int ts2, int ts1, int sjw, int brp);
    // R3: {ts2[14:12], ts1[11:8], sjw[7:6], brp[5:0]}
    return {3'(ts2), 4'(ts1), 2'(sjw), 6'(brp)};
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_tx(output int t);
    do @(negedge clk); while (!tx_point_o);
    t = cyc;
  endtask

  task automatic wait_smp(output int t);
    do @(negedge clk); while (!sample_o);
    t = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse_rx();
    rx = 1'b0;
    @(negedge clk);
    rx = 1'b1;
  endtask

  // config D: P=2, T1=6, T2=4, S=2
  task automatic seg1_edge(input string rq, input int k, input int ext);
    int t0, ts;
    wait_tx(t0);
    wait_until(t0 + 2 + 2 * k);
    pulse_rx();
    wait_smp(ts);
    chk(rq, ts - t0, (7 + ext) * 2);
  endtask

  task automatic seg2_edge(input string rq, input int k, input int q);
    int t0, ts, t1;
    wait_tx(t0);
    wait_smp(ts);
    wait_until(ts + 2 * k);
    pulse_rx();
    wait_tx(t1);
    chk(rq, t1 - ts, q * 2);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R1: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int r, t, t0, t1, t2, ts, x;
    btr = mk(2, 3, 0, 0);
    repeat (3) @(negedge clk);
    chk("R5", int'(tx_point_o), 1);
    chk("R5", int'(sample_o), 0);
    r = cyc;
    rst_n = 1'b1;
    wait_smp(t);
    chk("R5", t - r, 5);

    // sweep: prescaler 0..2, all phase field values
    for (int b = 0; b < 3; b++) begin
      for (int s1 = 0; s1 < 16; s1++) begin
        for (int s2 = 0; s2 < 8; s2++) begin
          int p, t2q;
          btr = mk(s2, s1, 0, b);
          wait_tx(t0);
          wait_smp(ts);
          wait_tx(t1);
          p   = b + 1;
          t2q = (s2 + 1 < 2) ? 2 : s2 + 1;
          chk("R2", ts - t0, (2 + s1) * p);
          chk((s2 == 0) ? "R4" : "R1", t1 - t0, (2 + s1 + t2q) * p);
        end
      end
    end

    // R12: mid-bit change applies to next bit
    btr = mk(2, 3, 0, 0);
    wait_tx(t0);
    wait_tx(t0);
    repeat (2) @(negedge clk);
    btr = mk(1, 1, 0, 1);
    wait_tx(t1);
    wait_tx(t2);
    chk("R12", t1 - t0, 8);
    chk("R12", t2 - t1, 10);

    // R6: hard sync, P=2 T1=4 T2=3
    btr = mk(2, 3, 1, 1);
    wait_tx(t0);
    wait_tx(t0);
    wait_until(t0 + 9);
    x = cyc;
    pulse_rx();
    chk("R6", int'(tx_point_o), 1);
    wait_smp(ts);
    chk("R6", ts - (x + 1), 10);
    hs_en = 1'b0;
    wait_tx(t0);
    wait_until(t0 + 5);
    pulse_rx();
    wait_tx(t1);
    chk("R6", t1 - t0, 16);

    // resynchronization while busy
    idle = 1'b0;
    btr  = mk(3, 5, 1, 1);
    wait_tx(t0);
    seg1_edge("R7", 0, 1);
    seg1_edge("R7", 3, 2);
    seg2_edge("R8", 0, 2);
    seg2_edge("R8", 2, 3);
    seg2_edge("R8", 3, 4);

    // R9
    wait_tx(t0);
    wait_until(t0 + 1);
    pulse_rx();
    wait_smp(ts);
    chk("R9", ts - t0, 14);

    // R10
    wait_tx(t0);
    wait_until(t0 + 4);
    pulse_rx();
    wait_until(t0 + 10);
    pulse_rx();
    wait_smp(ts);
    chk("R10", ts - t0, 18);

    // R11
    tx_dom = 1'b1;
    seg1_edge("R11", 2, 0);
    tx_dom = 1'b0;

    // R3: jump-width field 3 -> S=4
    btr = mk(3, 5, 3, 1);
    wait_tx(t0);
    seg1_edge("R3", 5, 4);

    chk("R13", ovl, 0);
    chk("R13", wide, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule